// File: doc/BRIEF.md
# Tag-Broadcast Reservation Station

This block is the issue window for one functional unit class in an out-of-order core. Instructions come in through the issue stream, each naming one destination register and two source registers. An accepted instruction takes a free station entry. Each source is taken from the register status table at once if its value is there. If it is not, the entry keeps the tag of the station entry that will produce the value. The destination register is then renamed to the new entry's tag. Because values are copied at issue and every destination gets a fresh name, write-after-read and write-after-write hazards never hold up issue. The only cause of an issue stall is a full station.

Results come back on a single result broadcast: a valid bit, a tag and a data word. Every waiting source whose tag matches takes the data. A register in the status table takes the value and becomes available only when its current tag is the broadcast tag. The station entry with that tag is released in the same cycle.

Each cycle, the oldest entry that has both operands and has not yet been sent is offered on the dispatch stream to the functional unit.

Top module: `tagbus_resv_station`

Both streams follow valid/ready rules:
- Issue is accepted in a cycle where `iss_valid` and `iss_ready` are both high.
- `iss_ready` does not depend on `iss_valid`.
- Dispatch completes in a cycle where `disp_valid` and `disp_ready` are both high.
- When an offer is not taken, the same entry and the same operands remain on the dispatch port until they are taken.

The result broadcast has no back-pressure.

## Requirements
- R1: `iss_ready` is high exactly when at least one of the 4 entries is free. An issue with `iss_ready` low has no effect. A source or destination that matches a register which is still pending never lowers `iss_ready`.
- R2: An accepted issue takes the free entry with the lowest index. That index (0 to 3) is shown on `iss_tag` in the cycle of the issue and serves as the entry's tag from then on.
- R3: A source whose register is not pending is copied at issue from the register status table. After reset, register i (0 to 7) holds the value i and no register is pending.
- R4: An accepted issue marks its destination register pending under the new tag, taking effect from the next cycle. A later source that reads that register waits for that tag and is not dispatched before it arrives.
- R5: A waiting source whose stored tag equals the broadcast tag, while `cdb_valid` is high, captures `cdb_data` and becomes ready in the next cycle.
- R6: A pending register takes `cdb_data` and stops being pending only when its current tag equals the broadcast tag. Once a register has been renamed again, it waits only for the newer tag.
- R7: `disp_valid` is high when some entry that has not been sent has both sources ready. The entry offered is the oldest such entry by order of issue, and `disp_a`/`disp_b` carry its operands.
- R8: A source that, at issue, reads a register pending on the tag being broadcast in that same cycle takes `cdb_data` directly and is ready from the next cycle.
- R9: When `cdb_valid` is high, the entry whose tag equals `cdb_tag` is freed. An entry that has been dispatched is not offered again. An offer with `disp_ready` low stays the same, entry and operands, until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request present |
| iss_ready | output | 1 | A station entry is free |
| iss_dst | input | 3 | Destination register |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| iss_tag | output | 2 | Tag of the entry an issue would take |
| disp_valid | output | 1 | An entry is offered for execution |
| disp_ready | input | 1 | Functional unit takes the offer |
| disp_tag | output | 2 | Tag of the offered entry |
| disp_a | output | 16 | First operand of the offered entry |
| disp_b | output | 16 | Second operand of the offered entry |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | 2 | Tag of the broadcast result |
| cdb_data | input | 16 | Broadcast result value |

## Verification
The hardest case to bring about is a broadcast in the same cycle as an issue whose source depends on the tag being broadcast. The station must have a free entry while the broadcasting entry is still allocated, and the producer must already have been dispatched. A directed sequence sets this up: it issues a producer, dispatches it, and then issues the consumer in the same cycle as the producer's result. After that, long random runs issue, hold back the dispatch stream and return results. They keep the station near full and often catch a register renamed again while an older result for it is still outstanding.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  parameter int unsigned RS_ENTRIES = 4;
  parameter int unsigned RS_NREG    = 8;
  parameter int unsigned RS_DATA_W  = 16;
endpackage

// File: rtl/rsv_regstat.sv
module rsv_regstat #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned RA_W   = $clog2(NREG),
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   rd1_i,
  input  logic [RA_W-1:0]   rd2_i,
  input  logic              ren_i,
  input  logic [RA_W-1:0]   ren_reg_i,
  input  logic [TAG_W-1:0]  ren_tag_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic              s1_rdy_o,
  output logic [TAG_W-1:0]  s1_tag_o,
  output logic [DATA_W-1:0] s1_val_o,
  output logic              s2_rdy_o,
  output logic [TAG_W-1:0]  s2_tag_o,
  output logic [DATA_W-1:0] s2_val_o
);
  logic              busy_q [NREG];
  logic [TAG_W-1:0]  tag_q  [NREG];
  logic [DATA_W-1:0] val_q  [NREG];

  always_comb begin
    s1_tag_o = tag_q[rd1_i];
    s2_tag_o = tag_q[rd2_i];
    if (!busy_q[rd1_i]) begin
      s1_rdy_o = 1'b1; s1_val_o = val_q[rd1_i];
    end else if (cdb_valid_i && cdb_tag_i == tag_q[rd1_i]) begin
      s1_rdy_o = 1'b1; s1_val_o = cdb_data_i;
    end else begin
      s1_rdy_o = 1'b0; s1_val_o = val_q[rd1_i];
    end
    if (!busy_q[rd2_i]) begin
      s2_rdy_o = 1'b1; s2_val_o = val_q[rd2_i];
    end else if (cdb_valid_i && cdb_tag_i == tag_q[rd2_i]) begin
      s2_rdy_o = 1'b1; s2_val_o = cdb_data_i;
    end else begin
      s2_rdy_o = 1'b0; s2_val_o = val_q[rd2_i];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit, ren_here;
    assign hit      = cdb_valid_i && busy_q[g] && (tag_q[g] == cdb_tag_i);
    assign ren_here = ren_i && (ren_reg_i == RA_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q[g] <= 1'b0;
        tag_q[g]  <= '0;
        val_q[g]  <= DATA_W'(g);
      end else begin
        if (hit) begin
          val_q[g]  <= cdb_data_i;
          busy_q[g] <= 1'b0;
        end
        if (ren_here) begin
          busy_q[g] <= 1'b1;
          tag_q[g]  <= ren_tag_i;
        end
      end
    end

    // R6
    reg_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !ren_here |=> !busy_q[g] && val_q[g] == $past(cdb_data_i));
    // R6
    reg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q[g] && !hit && !ren_here |=> busy_q[g] && $stable(val_q[g]) && $stable(tag_q[g]));
    // R4
    reg_rename_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ren_here |=> busy_q[g] && tag_q[g] == $past(ren_tag_i));
  end
endmodule

// File: rtl/rsv_entry.sv
module rsv_entry #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 2,
  parameter int unsigned AGE_W  = 2,
  parameter int unsigned MY_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              alloc_any_i,
  input  logic              free_any_i,
  input  logic [AGE_W-1:0]  free_age_i,
  input  logic              s1_rdy_i,
  input  logic [TAG_W-1:0]  s1_tag_i,
  input  logic [DATA_W-1:0] s1_val_i,
  input  logic              s2_rdy_i,
  input  logic [TAG_W-1:0]  s2_tag_i,
  input  logic [DATA_W-1:0] s2_val_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  input  logic              disp_fire_i,
  output logic              valid_o,
  output logic              ready_o,
  output logic [AGE_W-1:0]  age_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  logic              valid_q, sent_q, r1_q, r2_q;
  logic [TAG_W-1:0]  t1_q, t2_q;
  logic [DATA_W-1:0] v1_q, v2_q;
  logic [AGE_W-1:0]  age_q;
  logic              hit_self, wake1, wake2, older_gone;

  assign hit_self   = cdb_valid_i && valid_q && (cdb_tag_i == TAG_W'(MY_IDX));
  assign wake1      = cdb_valid_i && valid_q && !r1_q && (cdb_tag_i == t1_q);
  assign wake2      = cdb_valid_i && valid_q && !r2_q && (cdb_tag_i == t2_q);
  assign older_gone = free_any_i && !hit_self && (age_q > free_age_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0; sent_q <= 1'b0; r1_q <= 1'b0; r2_q <= 1'b0;
      t1_q <= '0; t2_q <= '0; v1_q <= '0; v2_q <= '0; age_q <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1; sent_q <= 1'b0;
      r1_q <= s1_rdy_i; t1_q <= s1_tag_i; v1_q <= s1_val_i;
      r2_q <= s2_rdy_i; t2_q <= s2_tag_i; v2_q <= s2_val_i;
      age_q <= '0;
    end else begin
      if (hit_self)    valid_q <= 1'b0;
      if (disp_fire_i) sent_q  <= 1'b1;
      if (wake1) begin r1_q <= 1'b1; v1_q <= cdb_data_i; end
      if (wake2) begin r2_q <= 1'b1; v2_q <= cdb_data_i; end
      if (valid_q) age_q <= age_q + AGE_W'(alloc_any_i) - AGE_W'(older_gone);
    end
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q && !sent_q && r1_q && r2_q;
  assign age_o   = age_q;
  assign a_o     = v1_q;
  assign b_o     = v2_q;

  // R5
  src1_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake1 |=> r1_q && v1_q == $past(cdb_data_i));
  // R5
  src2_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake2 |=> r2_q && v2_q == $past(cdb_data_i));
  // R9
  entry_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_self |=> !valid_q);
  // R9
  sent_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && sent_q && !hit_self |=> !ready_o);
endmodule

// File: rtl/rsv_select.sv
module rsv_select #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned TAG_W   = 2,
  parameter int unsigned AGE_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ENTRIES-1:0]       rdy_vec_i,
  input  logic [ENTRIES*AGE_W-1:0] ages_i,
  input  logic                     disp_ready_i,
  output logic                     disp_valid_o,
  output logic [TAG_W-1:0]         disp_tag_o
);
  logic             found;
  logic [TAG_W-1:0] best_tag;
  logic [AGE_W-1:0] best_age;
  logic             hold_q;
  logic [TAG_W-1:0] hold_tag_q;

  always_comb begin
    found    = 1'b0;
    best_tag = '0;
    best_age = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rdy_vec_i[i] && (!found || ages_i[i*AGE_W +: AGE_W] > best_age)) begin
        found    = 1'b1;
        best_tag = TAG_W'(i);
        best_age = ages_i[i*AGE_W +: AGE_W];
      end
    end
  end

  assign disp_valid_o = hold_q || found;
  assign disp_tag_o   = hold_q ? hold_tag_q : best_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      hold_tag_q <= '0;
    end else begin
      hold_q     <= disp_valid_o && !disp_ready_i;
      hold_tag_q <= disp_tag_o;
    end
  end

  // R7
  pick_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid_o |-> rdy_vec_i[disp_tag_o]);
  // R7
  idle_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_valid_o |-> rdy_vec_i == '0);
endmodule

// File: rtl/tagbus_resv_station.sv
module tagbus_resv_station
  import rsv_pkg::*;
#(
  parameter int unsigned ENTRIES = RS_ENTRIES,
  parameter int unsigned NREG    = RS_NREG,
  parameter int unsigned DATA_W  = RS_DATA_W,
  localparam int unsigned TAG_W  = $clog2(ENTRIES),
  localparam int unsigned AGE_W  = $clog2(ENTRIES),
  localparam int unsigned RA_W   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [RA_W-1:0]   iss_dst,
  input  logic [RA_W-1:0]   iss_src1,
  input  logic [RA_W-1:0]   iss_src2,
  output logic [TAG_W-1:0]  iss_tag,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [TAG_W-1:0]  disp_tag,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data
);
  logic [ENTRIES-1:0]       valid_vec, rdy_vec;
  logic [ENTRIES*AGE_W-1:0] ages;
  logic [DATA_W-1:0]        a_arr [ENTRIES];
  logic [DATA_W-1:0]        b_arr [ENTRIES];
  logic                     iss_fire, disp_fire, free_any;
  logic [AGE_W-1:0]         free_age;
  logic                     s1_rdy, s2_rdy;
  logic [TAG_W-1:0]         s1_tag, s2_tag;
  logic [DATA_W-1:0]        s1_val, s2_val;

  always_comb begin
    iss_ready = 1'b0;
    iss_tag   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        iss_ready = 1'b1;
        iss_tag   = TAG_W'(i);
      end
    end
  end

  assign iss_fire  = iss_valid && iss_ready;
  assign disp_fire = disp_valid && disp_ready;
  assign free_any  = cdb_valid && valid_vec[cdb_tag];
  assign free_age  = ages[cdb_tag*AGE_W +: AGE_W];

  rsv_regstat #(.NREG(NREG), .RA_W(RA_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_regstat (
    .clk(clk), .rst_n(rst_n),
    .rd1_i(iss_src1), .rd2_i(iss_src2),
    .ren_i(iss_fire), .ren_reg_i(iss_dst), .ren_tag_i(iss_tag),
    .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_data_i(cdb_data),
    .s1_rdy_o(s1_rdy), .s1_tag_o(s1_tag), .s1_val_o(s1_val),
    .s2_rdy_o(s2_rdy), .s2_tag_o(s2_tag), .s2_val_o(s2_val)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    rsv_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .AGE_W(AGE_W), .MY_IDX(e)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc_i(iss_fire && iss_tag == TAG_W'(e)),
      .alloc_any_i(iss_fire), .free_any_i(free_any), .free_age_i(free_age),
      .s1_rdy_i(s1_rdy), .s1_tag_i(s1_tag), .s1_val_i(s1_val),
      .s2_rdy_i(s2_rdy), .s2_tag_i(s2_tag), .s2_val_i(s2_val),
      .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_data_i(cdb_data),
      .disp_fire_i(disp_fire && disp_tag == TAG_W'(e)),
      .valid_o(valid_vec[e]), .ready_o(rdy_vec[e]),
      .age_o(ages[e*AGE_W +: AGE_W]),
      .a_o(a_arr[e]), .b_o(b_arr[e])
    );
  end

  rsv_select #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .AGE_W(AGE_W)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .rdy_vec_i(rdy_vec), .ages_i(ages), .disp_ready_i(disp_ready),
    .disp_valid_o(disp_valid), .disp_tag_o(disp_tag)
  );

  assign disp_a = a_arr[disp_tag];
  assign disp_b = b_arr[disp_tag];

  // R2
  alloc_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> valid_vec[$past(iss_tag)]);
  // R9
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid && disp_tag == $past(disp_tag)
      && disp_a == $past(disp_a) && disp_b == $past(disp_b));
  // R1
  full_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready && !free_any |=> !iss_ready);
endmodule

// File: tb/tb_tagbus_resv_station.sv
module tb_tagbus_resv_station;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0, disp_ready = 1'b0, cdb_valid = 1'b0;
  logic [2:0]  iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
  logic [1:0]  cdb_tag = '0;
  logic [15:0] cdb_data = '0;
  logic        iss_ready, disp_valid;
  logic [1:0]  iss_tag, disp_tag;
  logic [15:0] disp_a, disp_b;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tagbus_resv_station dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_dst(iss_dst),
    .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_tag(iss_tag),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .disp_a(disp_a), .disp_b(disp_b),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
  );

  // bench model
  bit      m_rbusy [8];
  int      m_rtag  [8];
  int      m_rval  [8];
  bit      e_valid [4], e_sent [4], e_r1 [4], e_r2 [4];
  int      e_t1 [4], e_t2 [4], e_v1 [4], e_v2 [4], e_seq [4];
  int      seqctr;
  bit      hold_v;
  int      hold_t;

  task automatic model_reset();
    for (int r = 0; r < 8; r++) begin m_rbusy[r] = 0; m_rtag[r] = 0; m_rval[r] = r; end
    for (int i = 0; i < 4; i++) begin
      e_valid[i] = 0; e_sent[i] = 0; e_r1[i] = 0; e_r2[i] = 0; e_seq[i] = 0;
    end
    seqctr = 0; hold_v = 0; hold_t = 0;
  endtask

  function automatic bit exp_ready();
    for (int i = 0; i < 4; i++) if (!e_valid[i]) return 1;
    return 0;
  endfunction

  function automatic int exp_tag();
    for (int i = 0; i < 4; i++) if (!e_valid[i]) return i;
    return 0;
  endfunction

  function automatic int exp_disp();  // -1 when nothing offered
    int best = -1;
    if (hold_v) return hold_t;
    for (int i = 0; i < 4; i++)
      if (e_valid[i] && !e_sent[i] && e_r1[i] && e_r2[i])
        if (best < 0 || e_seq[i] < e_seq[best]) best = i;
    return best;
  endfunction

  task automatic read_src(input int r, input bit cv, input int ct, input int cd,
                          output bit rdy, output int tg, output int vl);
    tg = m_rtag[r];
    if (!m_rbusy[r]) begin rdy = 1; vl = m_rval[r]; end
    else if (cv && ct == m_rtag[r]) begin rdy = 1; vl = cd; end
    else begin rdy = 0; vl = 0; end
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic step(input bit iv, input int dst, input int s1, input int s2,
                      input bit dr, input bit cv, input int ct, input int cd);
    bit er, fi, fd, r1, r2;
    int et, ed, t1, t2, v1, v2;
    @(negedge clk);
    iss_valid = iv; iss_dst = 3'(dst); iss_src1 = 3'(s1); iss_src2 = 3'(s2);
    disp_ready = dr; cdb_valid = cv; cdb_tag = 2'(ct); cdb_data = 16'(cd);
    #1;
    er = exp_ready(); et = exp_tag(); ed = exp_disp();
    chk("R1 R9 iss_ready", 32'(iss_ready), 32'(er));
    if (er) chk("R2 iss_tag", 32'(iss_tag), 32'(et));
    chk("R4 R7 disp_valid", 32'(disp_valid), 32'(ed >= 0));
    if (ed >= 0) begin
      chk("R7 R9 disp_tag", 32'(disp_tag), 32'(ed));
      chk("R3 R5 R6 R8 disp_a", 32'(disp_a), 32'(e_v1[ed]));
      chk("R3 R5 R6 R8 disp_b", 32'(disp_b), 32'(e_v2[ed]));
    end
    @(posedge clk);
    fi = iv && er;
    fd = (ed >= 0) && dr;
    read_src(s1, cv, ct, cd, r1, t1, v1);
    read_src(s2, cv, ct, cd, r2, t2, v2);
    for (int i = 0; i < 4; i++) begin
      if (e_valid[i]) begin
        if (cv && !e_r1[i] && ct == e_t1[i]) begin e_r1[i] = 1; e_v1[i] = cd; end
        if (cv && !e_r2[i] && ct == e_t2[i]) begin e_r2[i] = 1; e_v2[i] = cd; end
      end
      if (fd && i == ed) e_sent[i] = 1;
      if (cv && ct == i) e_valid[i] = 0;
    end
    if (fi) begin
      e_valid[et] = 1; e_sent[et] = 0; e_seq[et] = seqctr++;
      e_r1[et] = r1; e_t1[et] = t1; e_v1[et] = v1;
      e_r2[et] = r2; e_t2[et] = t2; e_v2[et] = v2;
    end
    if (cv)
      for (int r = 0; r < 8; r++)
        if (m_rbusy[r] && m_rtag[r] == ct) begin m_rbusy[r] = 0; m_rval[r] = cd; end
    if (fi) begin m_rbusy[dst] = 1; m_rtag[dst] = et; end
    hold_v = (ed >= 0) && !dr;
    hold_t = ed;
  endtask

  function automatic int pick_done();  // a dispatched entry awaiting its result, -1 if none
    int st = $urandom_range(0, 3);
    for (int k = 0; k < 4; k++) begin
      int i = (st + k) % 4;
      if (e_valid[i] && e_sent[i]) return i;
    end
    return -1;
  endfunction

  task automatic drain();
    for (int n = 0; n < 40; n++) begin
      int d = pick_done();
      step(0, 0, 0, 0, 1, d >= 0, (d >= 0) ? d : 0, $urandom & 16'hFFFF);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd1337));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state, R1 R2 R3: first issue reads reset values
    step(1, 1, 5, 3, 0, 0, 0, 0);          // entry0: a=5 b=3
    // R4 WAW and true dependence: dst r1 again, src r1 waits on tag0
    step(1, 1, 1, 2, 0, 0, 0, 0);          // entry1
    step(1, 2, 1, 1, 0, 0, 0, 0);          // entry2 waits tag1
    step(1, 3, 0, 7, 0, 0, 0, 0);          // entry3 ready, station full
    // R1: full, issue ignored; R9: offer held while disp_ready low
    step(1, 4, 4, 4, 0, 0, 0, 0);
    step(1, 4, 4, 4, 0, 0, 0, 0);
    // R7: oldest ready goes first (entry0, then entry3)
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    // R5 R6: result of tag0 wakes entry1; r1 stays pending on tag1
    step(0, 0, 0, 0, 0, 1, 0, 16'h1234);
    step(1, 5, 1, 0, 1, 0, 0, 0);          // new entry in slot0 waits tag1
    step(0, 0, 0, 0, 1, 1, 3, 16'h00aa);
    drain();

    // R8: producer dispatched, then its result and a dependent issue in one cycle
    begin
      int tp;
      tp = exp_tag();
      step(1, 6, 2, 3, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 0, 0, 0);
      step(1, 7, 6, 6, 0, 1, tp, 16'hbeef);
      step(0, 0, 0, 0, 1, 0, 0, 0);
      drain();
    end

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int d = pick_done();
      bit cv = (d >= 0) && ($urandom_range(0, 99) < 45);
      step($urandom_range(0, 99) < 60, $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 7), $urandom_range(0, 99) < 65, cv, cv ? d : 0,
           $urandom & 16'hFFFF);
    end
    drain();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired R1");
    finish_run();
  end
endmodule